// File: doc/BRIEF.md
# Dual-Channel Complex Serial Output Framer

This block turns one complex sample per receive channel into a serial bit stream. A single-cycle sample strobe from upstream hands over the I and Q words of channel A and channel B. The block captures them, together with the four mode controls, and sends the words most significant bit first. Alongside the data it drives a serial clock, a frame strobe and a ready pulse. The serial clock runs at the system clock divided by `DIV`. It toggles only while a burst is in flight. Between bursts it rests at its idle level, and the data and strobe lines rest at zero.

The mode controls choose the layout of the burst:
- Split mode puts channel A on `ser_a` and channel B on `ser_b`.
- Multiplexed mode sends all four words on `ser_a` while `ser_b` stays low.
- Unpacked or packed framing decides whether a strobe marks every word or every I/Q pair.
- A one-strobe mode reduces that to a single strobe per burst.
- A polarity control inverts the serial clock.

A strobe that arrives while a burst is still running is dropped, and a sticky overrun flag is raised. A strobe timed to the final system cycle of a burst is accepted, so bursts can follow each other with no gap.

Top module: `cplx_ser_framer`

## Requirements
- R1: A synchronous active-high reset, whether applied at idle or mid-burst, leaves `ser_clk`, `ser_fs`, `ser_a`, `ser_b`, `rdy_o` and `ovr_o` all at 0 on the cycle after the reset edge.
- R2: Timing of a burst:
  - On the system cycle after an accepted strobe, the first bit appears.
  - Each bit is held for `DIV` system cycles and words are sent MSB first.
  - With `ck_inv`=0, `ser_clk` is high for the first `DIV/2` cycles of each bit and low for the rest.
- R3: With `mux_sel`=0, `ser_a` carries IA then QA, and `ser_b` carries IB then QB, for 32 bits in total.
- R4: With `mux_sel`=1, `ser_a` carries IA, QA, IB, QB in that order for 64 bits, and `ser_b` stays 0 for the whole burst.
- R5: With `fs_once`=0, `ser_fs` is high during bit k of a burst and low during every other bit. Which values of k count depends on framing:
  - unpacked (`pack_sel`=0): every k that is a multiple of 16;
  - packed (`pack_sel`=1): every k that is a multiple of 32.
- R6: With `fs_once`=1, `ser_fs` is high only during bit 0 of the burst, for one serial clock period.
- R7: `rdy_o` is high for exactly the first two system cycles of each burst, and rises together with `ser_fs`.
- R8: With `ck_inv`=1, `ser_clk` is the inverse of the R2 waveform, and it idles high after that burst.
- R9: Once the last bit of a burst has been sent, `ser_clk` rests at the idle level of that burst's polarity, and `ser_fs`, `ser_a` and `ser_b` are 0, until the next accepted strobe.
- R10: Sample words and mode inputs are captured at the accepting edge. Later changes to them have no effect on the burst in flight.
- R11: A strobe that arrives while a burst runs (other than on its final cycle) has these effects:
  - it sets `ovr_o`, which stays set until reset;
  - it leaves the current burst unchanged;
  - its sample is discarded, so no new burst starts.
- R12: A strobe that arrives in the final system cycle of a burst is accepted without overrun, and the next burst starts on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe: a new sample set is present |
| ia_i | input | W | Channel A in-phase word |
| qa_i | input | W | Channel A quadrature word |
| ib_i | input | W | Channel B in-phase word |
| qb_i | input | W | Channel B quadrature word |
| mux_sel | input | 1 | 1: both channels on `ser_a`; 0: one pin per channel |
| pack_sel | input | 1 | 1: strobe per I/Q pair; 0: strobe per word |
| fs_once | input | 1 | 1: a single strobe per burst |
| ck_inv | input | 1 | 1: invert the serial clock |
| ser_clk | output | 1 | Gated serial clock |
| ser_fs | output | 1 | Frame strobe |
| ser_a | output | 1 | Serial data pin A |
| ser_b | output | 1 | Serial data pin B |
| rdy_o | output | 1 | Two-cycle ready pulse at the start of a burst |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest situations to reach from the ports are the two that hinge on the exact cycle a strobe lands relative to the end of a burst. A strobe one cycle too early must be counted as an overrun. A strobe on the final cycle must be taken cleanly as a back-to-back burst. The stimulus counts system cycles from the accepting edge and places a second strobe once in the middle of a burst and once on its very last cycle. In both cases it checks the old stream, the flag and the first bit of the new burst. Every table vector also inverts all mode and data inputs right after the strobe, so that any leakage of live inputs into the running burst shows up.

// File: rtl/csf_pkg.sv
package csf_pkg;

    typedef struct packed {
        logic mux;
        logic pack;
        logic once;
        logic inv;
    } csf_mode_t;

endpackage

// File: rtl/csf_mark.sv
module csf_mark #(
    parameter int W  = 16,
    parameter int BW = 6
) (
    input  logic [BW-1:0] bitc,
    input  logic          pack,
    input  logic          once,
    output logic          mark
);
    localparam logic [BW-1:0] WORD = BW'(W);
    localparam logic [BW-1:0] PAIR = BW'(2 * W);

    always_comb begin
        if (once) begin
            mark = (bitc == '0);
        end else if (pack) begin
            mark = ((bitc % PAIR) == '0);
        end else begin
            mark = ((bitc % WORD) == '0);
        end
    end
endmodule

// File: rtl/csf_lane.sv
module csf_lane #(
    parameter int W  = 16,
    parameter int BW = 6
) (
    input  logic [4*W-1:0] sha,
    input  logic [2*W-1:0] shb,
    input  logic [BW-1:0]  bitc,
    input  logic           mux,
    output logic           a_bit,
    output logic           b_bit
);
    localparam int LMAX = 4 * W;
    localparam logic [BW-1:0] TOP  = BW'(LMAX - 1);
    localparam logic [BW-1:0] BLEN = BW'(2 * W);

    logic [BW-1:0]   idx;
    logic [LMAX-1:0] shb_ext;

    always_comb begin
        idx     = TOP - bitc;
        shb_ext = {{(2 * W){1'b0}}, shb};
        a_bit   = sha[idx];
        b_bit   = (!mux && (bitc < BLEN)) ? shb_ext[BW'(2 * W - 1) - bitc] : 1'b0;
    end
endmodule

// File: rtl/csf_rdy.sv
module csf_rdy #(
    parameter int PULSE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic rdy
);
    localparam int CW = $clog2(PULSE + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start) begin
            cnt_d = CW'(PULSE);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rdy = (cnt_q != '0);
endmodule

// File: rtl/cplx_ser_framer.sv
module cplx_ser_framer
    import csf_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_stb,
    input  logic [W-1:0] ia_i,
    input  logic [W-1:0] qa_i,
    input  logic [W-1:0] ib_i,
    input  logic [W-1:0] qb_i,
    input  logic         mux_sel,
    input  logic         pack_sel,
    input  logic         fs_once,
    input  logic         ck_inv,
    output logic         ser_clk,
    output logic         ser_fs,
    output logic         ser_a,
    output logic         ser_b,
    output logic         rdy_o,
    output logic         ovr_o
);
    localparam int LMAX = 4 * W;
    localparam int BW   = $clog2(LMAX);
    localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [BW-1:0] LAST_MUX   = BW'(LMAX - 1);
    localparam logic [BW-1:0] LAST_SPLIT = BW'(2 * W - 1);

    typedef struct packed {
        logic            busy;
        logic [PW-1:0]   ph;
        logic [BW-1:0]   bitc;
        logic [LMAX-1:0] sha;
        logic [2*W-1:0]  shb;
        csf_mode_t       md;
        logic            ovr;
    } core_t;

    typedef struct packed {
        logic sck;
        logic fs;
        logic a;
        logic b;
    } pins_t;

    core_t s_d, s_q;
    pins_t o_d, o_q;

    logic          ph_end, fin, accept;
    logic [BW-1:0] last_bit;
    logic          mark_w, a_w, b_w;
    logic          busy_w, mux_w;

    always_comb begin
        last_bit = s_q.md.mux ? LAST_MUX : LAST_SPLIT;
        ph_end   = (s_q.ph == PW'(DIV - 1));
        fin      = s_q.busy && ph_end && (s_q.bitc == last_bit);
        accept   = smp_stb && (!s_q.busy || fin);

        s_d = s_q;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.ph   = '0;
            s_d.bitc = '0;
            s_d.sha  = {ia_i, qa_i, ib_i, qb_i};
            s_d.shb  = {ib_i, qb_i};
            s_d.md   = '{mux: mux_sel, pack: pack_sel, once: fs_once, inv: ck_inv};
        end else if (s_q.busy) begin
            if (ph_end) begin
                s_d.ph = '0;
                if (fin) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.bitc = s_q.bitc + 1'b1;
                end
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
        if (smp_stb && !accept) begin
            s_d.ovr = 1'b1;
        end
    end

    csf_mark #(.W(W), .BW(BW)) u_mark (
        .bitc (s_d.bitc),
        .pack (s_d.md.pack),
        .once (s_d.md.once),
        .mark (mark_w)
    );

    csf_lane #(.W(W), .BW(BW)) u_lane (
        .sha   (s_d.sha),
        .shb   (s_d.shb),
        .bitc  (s_d.bitc),
        .mux   (s_d.md.mux),
        .a_bit (a_w),
        .b_bit (b_w)
    );

    always_comb begin
        o_d.sck = s_d.busy ? ((s_d.ph < PW'(HALF)) ^ s_d.md.inv) : s_d.md.inv;
        o_d.fs  = s_d.busy & mark_w;
        o_d.a   = s_d.busy & a_w;
        o_d.b   = s_d.busy & b_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
            o_q <= '0;
        end else begin
            s_q <= s_d;
            o_q <= o_d;
        end
    end

    csf_rdy #(.PULSE(2)) u_rdy (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .rdy   (rdy_o)
    );

    assign ser_clk = o_q.sck;
    assign ser_fs  = o_q.fs;
    assign ser_a   = o_q.a;
    assign ser_b   = o_q.b;
    assign ovr_o   = s_q.ovr;
    assign busy_w  = s_q.busy;
    assign mux_w   = s_q.md.mux;
endmodule

// File: rtl/csf_chk.sv
module csf_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic mux_lat,
    input logic ser_fs,
    input logic ser_a,
    input logic ser_b,
    input logic rdy_o,
    input logic ovr_o
);
    // R9: nothing on the data or strobe lines between bursts
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_a && !ser_b && !ser_fs));

    // R4: pin B is silent for a multiplexed burst
    assert_b_low_mux_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && mux_lat) |-> !ser_b);

    // R7: the ready pulse starts with a frame strobe
    assert_rdy_with_fs_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |-> ser_fs);

    // R7: the ready pulse lasts at least two cycles
    assert_rdy_two_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |=> rdy_o);

    // R7: the ready pulse lasts no more than two cycles
    assert_rdy_max_R7: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && $past(rdy_o)) |=> !rdy_o);

    // R11: the overrun flag is sticky
    assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ovr_o |=> ovr_o);

    // R11: an overrun can only arise from a strobe during a burst
    assert_ovr_needs_busy_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> $past(busy));
endmodule

bind cplx_ser_framer csf_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_w),
    .mux_lat (mux_w),
    .ser_fs  (ser_fs),
    .ser_a   (ser_a),
    .ser_b   (ser_b),
    .rdy_o   (rdy_o),
    .ovr_o   (ovr_o)
);

// File: tb/tb_cplx_ser_framer.sv
`timescale 1ns/1ps
module tb_cplx_ser_framer;
    localparam int W   = 16;
    localparam int DIV = 2;
    localparam int NV  = 7;

    // {mux, pack, once, inv, IA, QA, IB, QB}
    localparam logic [67:0] VEC [NV] = '{
        {4'b0000, 16'hA5C3, 16'h1234, 16'hF00F, 16'h8001},
        {4'b0100, 16'h0F0F, 16'hC0DE, 16'h7FFE, 16'h5AA5},
        {4'b0011, 16'hFFFF, 16'h0000, 16'h0001, 16'h8000},
        {4'b1000, 16'h1357, 16'h9BDF, 16'h2468, 16'hACE0},
        {4'b1101, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D},
        {4'b1010, 16'h8421, 16'h4812, 16'h3C3C, 16'hE1E1},
        {4'b1111, 16'h6996, 16'h9669, 16'h0FF0, 16'hF00F}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic [W-1:0] ia_i = '0, qa_i = '0, ib_i = '0, qb_i = '0;
    logic mux_sel = 1'b0, pack_sel = 1'b0, fs_once = 1'b0, ck_inv = 1'b0;
    logic ser_clk, ser_fs, ser_a, ser_b, rdy_o, ovr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cplx_ser_framer #(.W(W), .DIV(DIV)) dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb),
        .ia_i(ia_i), .qa_i(qa_i), .ib_i(ib_i), .qb_i(qb_i),
        .mux_sel(mux_sel), .pack_sel(pack_sel), .fs_once(fs_once), .ck_inv(ck_inv),
        .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_a(ser_a), .ser_b(ser_b),
        .rdy_o(rdy_o), .ovr_o(ovr_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [67:0] v);
        {mux_sel, pack_sel, fs_once, ck_inv} = v[67:64];
        {ia_i, qa_i, ib_i, qb_i} = v[63:0];
        smp_stb = 1'b1;
    endtask

    function automatic logic exp_fs(input int k, input logic pack, input logic once);
        if (once) return (k == 0);
        if (pack) return (k % 32) == 0;
        return (k % 16) == 0;
    endfunction

    // Walk one burst; starts and ends at a negedge
    task automatic run_vec(input logic [67:0] v);
        logic m, p, o, inv;
        logic [63:0] stream_a;
        logic [31:0] stream_b;
        int len;
        {m, p, o, inv} = v[67:64];
        stream_a = m ? v[63:0] : {v[63:32], 32'h0};
        stream_b = v[31:0];
        len = m ? 64 : 32;
        load(v);
        @(negedge clk);
        smp_stb = 1'b0;
        // R10: disturb every input right after capture
        {mux_sel, pack_sel, fs_once, ck_inv} = ~v[67:64];
        {ia_i, qa_i, ib_i, qb_i} = ~v[63:0];
        for (int c = 0; c < len * DIV; c++) begin
            int k;
            k = c / DIV;
            chk(inv ? "R8 sck" : "R2 sck", 64'(ser_clk), 64'(((c % DIV) < DIV / 2) ^ inv));
            chk(o ? "R6 fs" : "R5 fs", 64'(ser_fs), 64'(exp_fs(k, p, o)));
            chk(m ? "R4 R10 a" : "R3 R10 a", 64'(ser_a), 64'(stream_a[63 - k]));
            chk(m ? "R4 b" : "R3 b", 64'(ser_b), m ? 64'(0) : 64'(stream_b[31 - k]));
            chk("R7 rdy", 64'(rdy_o), 64'(c < 2));
            @(negedge clk);
        end
        chk("R9 idle clock", 64'(ser_clk), 64'(inv));
        chk("R9 idle lines", 64'({ser_fs, ser_a, ser_b, rdy_o}), 64'(0));
        chk("R11 no overrun", 64'(ovr_o), 64'(0));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reset outputs", 64'({ser_clk, ser_fs, ser_a, ser_b, rdy_o, ovr_o}), 64'(0));

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
        end

        // R12: back-to-back strobe on the final cycle of a split burst
        do_reset();
        load(VEC[0]);
        @(negedge clk);
        smp_stb = 1'b0;
        for (int c = 0; c < 32 * DIV; c++) begin
            if (c == 32 * DIV - 1) begin
                load({4'b0000, 16'hC000, 16'h0000, 16'h4000, 16'h0000});
            end
            @(negedge clk);
        end
        smp_stb = 1'b0;
        chk("R12 new burst fs", 64'(ser_fs), 64'(1));
        chk("R12 new burst rdy", 64'(rdy_o), 64'(1));
        chk("R12 new burst a msb", 64'(ser_a), 64'(1));
        chk("R12 new burst b msb", 64'(ser_b), 64'(0));
        chk("R12 no overrun", 64'(ovr_o), 64'(0));
        repeat (32 * DIV + 4) @(negedge clk);

        // R11: strobe in the middle of a burst is dropped
        do_reset();
        load(VEC[0]);
        @(negedge clk);
        smp_stb = 1'b0;
        for (int c = 0; c < 32 * DIV; c++) begin
            logic [31:0] sa;
            sa = VEC[0][63:32];
            chk("R11 stream kept", 64'(ser_a), 64'(sa[31 - c / DIV]));
            if (c > 10) chk("R11 flag set", 64'(ovr_o), 64'(1));
            if (c == 10) load({4'b1000, 16'h0000, 16'h0000, 16'h0000, 16'h0000});
            @(negedge clk);
            smp_stb = 1'b0;
        end
        chk("R11 sample dropped", 64'({ser_fs, ser_a, ser_b, rdy_o, ser_clk}), 64'(0));
        repeat (5) @(negedge clk);
        chk("R11 flag sticky", 64'(ovr_o), 64'(1));

        // R1: reset in the middle of a multiplexed burst
        load(VEC[4]);
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-burst reset", 64'({ser_clk, ser_fs, ser_a, ser_b, rdy_o, ovr_o}), 64'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 stays idle", 64'({ser_clk, ser_fs, ser_a, ser_b, rdy_o, ovr_o}), 64'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule